// File: doc/BRIEF.md
# Latched-Address Parallel NVRAM Controller

This block lets synchronous logic read and write single bytes in an asynchronous parallel nonvolatile RAM. The memory samples its address when chip enable falls and ignores later address changes. For a write, the level of write enable at that falling edge decides which signal times the write. The controller places the address one cycle before chip enable falls and holds it. It runs the access for a fixed number of clocks and then keeps chip enable high for a precharge interval. Only after that does it accept the next request.

The host sees a request/ready handshake. A request carries an address, a write flag and write data, and is taken only on a clock edge where ready is high. Read data is returned with a single-cycle valid pulse. The memory data bus is presented as three signals: a driven value, a driver enable and the sampled input. The board level builds the tri-state buffer from these. A parameter selects the write style: either write enable is low before chip enable falls, or write enable pulses inside the chip-enable window. A counter reports how many accepted accesses landed in the same 4-byte endurance row as the access just before them.

Top module: `nvram_latch_ctrl`

## Requirements
- R1: While reset is low and directly after it, chip enable, output enable and write enable are high, the data driver is off, ready is high, the read-valid pulse is low and the row-repeat counter is zero.
- R2: A request is accepted only on an edge where ready is high. Ready then stays low for exactly 1 + CYCLE_CLKS + PRECHARGE_CLKS cycles, and a request raised while ready is low starts no memory access.
- R3: The memory address is valid one cycle before chip enable falls and does not change while chip enable is low.
- R4: Every access holds chip enable low for exactly CYCLE_CLKS cycles, for reads and writes alike, and chip enable then stays high for at least PRECHARGE_CLKS cycles.
- R5: A read samples the data bus after output enable has been low for ACCESS_CLKS cycles. The byte appears on rd_data with a one-cycle rd_valid pulse ACCESS_CLKS + 1 cycles after acceptance, and it equals the byte most recently written to that address (0 for a never-written address).
- R6: The controller drives the data bus only during write accesses, only while output enable is high, and its driver is off at least one cycle before output enable falls; the memory and the controller never drive at once.
- R7: With WE_CTRL_WRITE = 0, write enable is already low when chip enable falls, so the memory treats the write as chip-enable timed, and write enable stays low for the whole chip-enable window.
- R8: With WE_CTRL_WRITE = 1, write enable is high when chip enable falls, goes low one cycle later and returns high one cycle before chip enable rises (low for CYCLE_CLKS - 2 cycles).
- R9: The row-repeat counter increments by one for each accepted request whose address bits [14:2] equal those of the previous accepted request; the first request after reset never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, request may be taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | One-cycle pulse with rd_data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data-bus driver enable |
| mem_dq_in | input | 8 | Sampled data bus |
| row_repeat_cnt | output | 16 | Accesses that hit the same 4-byte row as the previous one |

## Verification
Two controllers, one per write style, run from the same host stimulus. Each is connected to a pin-level memory model that latches the address on the chip-enable fall and records which write style it saw. Directed writes and read-backs at addresses 3 and 4, at the top address and at pairs inside one row separate correct row boundaries from off-by-one row decoding. Requests raised during a busy access show whether the handshake really blocks them. A long seeded random mix over a small pool of rows compares read data, counter values and access timing against bench-side expectations. It exposes stale address latching, wrong capture timing and bus contention.

// File: rtl/nvram_latch_ctrl.sv
module nvram_latch_ctrl #(
  parameter int AW             = 15,
  parameter int DW             = 8,
  parameter int ACCESS_CLKS    = 9,
  parameter int CYCLE_CLKS     = 17,
  parameter int PRECHARGE_CLKS = 2,
  parameter int WE_CTRL_WRITE  = 0,
  parameter int ROW_LSB        = 2,
  parameter int HOT_W          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic [HOT_W-1:0] row_repeat_cnt
);

  localparam int CMAX = (CYCLE_CLKS > PRECHARGE_CLKS) ? CYCLE_CLKS : PRECHARGE_CLKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = AW - ROW_LSB;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_PRE} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_q, wr_n;
  logic [RW-1:0] prev_row;
  logic          prev_ok;
  logic          take;
  logic          act_n, setup_n, hold_n, we_on;

  assign ready = (st == S_IDLE);
  assign take  = ready && req;
  assign wr_n  = take ? req_we : wr_q;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_IDLE:  if (req) st_n = S_SETUP;
      S_SETUP: begin st_n = S_ACT; cnt_n = '0; end
      S_ACT:
        if (cnt == CW'(CYCLE_CLKS - 1)) begin st_n = S_PRE; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      S_PRE:
        if (cnt == CW'(PRECHARGE_CLKS - 1)) begin st_n = S_IDLE; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      default: st_n = S_IDLE;
    endcase
  end

  assign act_n   = (st_n == S_ACT);
  assign setup_n = (st_n == S_SETUP);
  assign hold_n  = (st_n == S_PRE) && (cnt_n == '0);
  assign we_on   = (WE_CTRL_WRITE != 0)
                 ? (act_n && cnt_n != '0 && cnt_n != CW'(CYCLE_CLKS - 1))
                 : (setup_n || act_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      mem_addr  <= '0;
      mem_dq_out<= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      wr_q      <= wr_n;
      if (take) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !act_n;
      mem_oe_n  <= !(act_n && !wr_n);
      mem_we_n  <= !(wr_n && we_on);
      mem_dq_oe <= wr_n && (setup_n || act_n || hold_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (st == S_ACT && !wr_q && cnt == CW'(ACCESS_CLKS - 1)) begin
        rd_data  <= mem_dq_in;
        rd_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_row       <= '0;
      prev_ok        <= 1'b0;
      row_repeat_cnt <= '0;
    end else if (take) begin
      prev_row <= req_addr[AW-1:ROW_LSB];
      prev_ok  <= 1'b1;
      if (prev_ok && prev_row == req_addr[AW-1:ROW_LSB])
        row_repeat_cnt <= row_repeat_cnt + 1'b1;
    end
  end

endmodule

module nvram_latch_ctrl_chk #(
  parameter int AW            = 15,
  parameter int WE_CTRL_WRITE = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rd_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> (mem_addr == $past(mem_addr)));

  p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (mem_addr == $past(mem_addr)));

  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n));

  p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  generate
    if (WE_CTRL_WRITE == 0) begin : g_cec
      p_we_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && mem_dq_oe) |-> !mem_we_n);
    end else begin : g_wec
      p_we_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> mem_we_n);
      p_we_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    end
  endgenerate

endmodule

bind nvram_latch_ctrl nvram_latch_ctrl_chk #(.AW(AW), .WE_CTRL_WRITE(WE_CTRL_WRITE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/tb_nvram_latch_ctrl.sv
module nvram_model (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [14:0] addr,
  input  logic [7:0]  din,
  input  logic        din_en,
  output logic [7:0]  dout,
  output int          n_acc,
  output int          low_len,
  output int          we_low,
  output int          cec,
  output int          contention,
  output int          addr_moves
);
  logic [7:0]  mem [int];
  logic [14:0] lat = '0;
  logic [7:0]  rbyte = '0;
  int run_len = 0, run_we = 0;
  logic driving;

  initial begin n_acc = 0; cec = 0; end
  initial begin low_len = 0; we_low = 0; contention = 0; addr_moves = 0; end

  always @(negedge ce_n) begin
    lat   = addr;
    cec   = we_n ? 0 : 1;
    rbyte = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
    n_acc = n_acc + 1;
  end

  assign driving = !ce_n && !oe_n && (cec == 0);
  assign dout    = driving ? rbyte : 8'h00;

  always @(posedge clk) begin
    if (!ce_n) begin
      run_len = run_len + 1;
      if (!we_n) run_we = run_we + 1;
      if (!we_n && din_en) mem[int'(lat)] = din;
      if (addr != lat) addr_moves = addr_moves + 1;
      if (din_en && driving) contention = contention + 1;
    end else if (run_len != 0) begin
      low_len = run_len;
      we_low  = run_we;
      run_len = 0;
      run_we  = 0;
    end
  end
endmodule

module tb_nvram_latch_ctrl;
  localparam int ACC = 9, CYC = 17, PRE = 2;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic rdy_a, rv_a, ce_a, oe_a, we_a, doe_a;
  logic rdy_b, rv_b, ce_b, oe_b, we_b, doe_b;
  logic [7:0] rd_a, rd_b, dqo_a, dqo_b, dqi_a, dqi_b;
  logic [14:0] ma_a, ma_b;
  logic [15:0] hot_a, hot_b;
  int nacc_a, len_a, wel_a, cec_a, con_a, mov_a;
  int nacc_b, len_b, wel_b, cec_b, con_b, mov_b;

  int checks = 0, fails = 0;
  logic [7:0] shadow [int];
  logic [14:0] prev_addr;
  bit prev_ok = 0;
  int exp_hot = 0;

  always #4 clk = ~clk;

  nvram_latch_ctrl #(.ACCESS_CLKS(ACC), .CYCLE_CLKS(CYC), .PRECHARGE_CLKS(PRE), .WE_CTRL_WRITE(0)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(rdy_a), .rd_data(rd_a), .rd_valid(rv_a), .mem_ce_n(ce_a), .mem_oe_n(oe_a), .mem_we_n(we_a),
    .mem_addr(ma_a), .mem_dq_out(dqo_a), .mem_dq_oe(doe_a), .mem_dq_in(dqi_a), .row_repeat_cnt(hot_a));

  nvram_latch_ctrl #(.ACCESS_CLKS(ACC), .CYCLE_CLKS(CYC), .PRECHARGE_CLKS(PRE), .WE_CTRL_WRITE(1)) dut_we (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(rdy_b), .rd_data(rd_b), .rd_valid(rv_b), .mem_ce_n(ce_b), .mem_oe_n(oe_b), .mem_we_n(we_b),
    .mem_addr(ma_b), .mem_dq_out(dqo_b), .mem_dq_oe(doe_b), .mem_dq_in(dqi_b), .row_repeat_cnt(hot_b));

  nvram_model mdl_a (.clk(clk), .ce_n(ce_a), .oe_n(oe_a), .we_n(we_a), .addr(ma_a), .din(dqo_a),
    .din_en(doe_a), .dout(dqi_a), .n_acc(nacc_a), .low_len(len_a), .we_low(wel_a), .cec(cec_a),
    .contention(con_a), .addr_moves(mov_a));
  nvram_model mdl_b (.clk(clk), .ce_n(ce_b), .oe_n(oe_b), .we_n(we_b), .addr(ma_b), .din(dqo_b),
    .din_en(doe_b), .dout(dqi_b), .n_acc(nacc_b), .low_len(len_b), .we_low(wel_b), .cec(cec_b),
    .contention(con_b), .addr_moves(mov_b));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit same_row(input logic [14:0] a, input logic [14:0] b);
    return a[14:2] == b[14:2];
  endfunction

  function automatic int exp_read(input logic [14:0] a);
    return shadow.exists(int'(a)) ? int'(shadow[int'(a)]) : 0;
  endfunction

  task automatic do_op(input bit w, input logic [14:0] a, input logic [7:0] d, input bit poke);
    int n, rv_n, pulses, na0, nb0;
    logic [7:0] ga, gb;
    n = 0; rv_n = -1; pulses = 0; ga = 0; gb = 0;
    na0 = nacc_a; nb0 = nacc_b;
    @(negedge clk);
    while (!rdy_a) @(negedge clk);
    req = 1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    if (prev_ok && same_row(prev_addr, a)) exp_hot++;
    prev_addr = a; prev_ok = 1;
    while (!rdy_a) begin
      if (rv_a) begin pulses++; if (rv_n < 0) begin rv_n = n; ga = rd_a; gb = rd_b; end end
      if (poke && n == 3) begin req = 1; req_we = ~w; req_addr = a ^ 15'h0155; end
      if (poke && n == 4) req = 0;
      @(negedge clk);
      n++;
    end
    chk("R2 busy length", n, 1 + CYC + PRE);
    chk("R2 ready match", int'(rdy_b), 1);
    chk("R2 one access a", nacc_a - na0, 1);
    chk("R2 one access b", nacc_b - nb0, 1);
    chk("R4 ce low len a", len_a, CYC);
    chk("R4 ce low len b", len_b, CYC);
    chk("R9 row count a", int'(hot_a), exp_hot);
    chk("R9 row count b", int'(hot_b), exp_hot);
    if (w) begin
      shadow[int'(a)] = d;
      chk("R5 no pulse on write", pulses, 0);
      chk("R7 ce-timed write", cec_a, 1);
      chk("R7 we low span", wel_a, CYC);
      chk("R8 we-timed write", cec_b, 0);
      chk("R8 we low span", wel_b, CYC - 2);
    end else begin
      chk("R5 one pulse", pulses, 1);
      chk("R5 valid timing", rv_n, ACC + 1);
      chk("R5 data a", int'(ga), exp_read(a));
      chk("R5 data b", int'(gb), exp_read(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [14:0] rows [16];
    int rnd;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(rdy_a), 1);
    chk("R1 ce in reset", int'(ce_a & ce_b), 1);
    chk("R1 oe/we in reset", int'(oe_a & we_a & oe_b & we_b), 1);
    chk("R1 driver off", int'(doe_a | doe_b), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid low", int'(rv_a | rv_b), 0);
    chk("R1 counter zero", int'(hot_a) + int'(hot_b), 0);
    chk("R1 ready after reset", int'(rdy_a & rdy_b), 1);

    do_op(0, 15'h0010, 8'h00, 0);
    do_op(1, 15'h0000, 8'hA5, 0);
    do_op(0, 15'h0000, 8'h00, 0);
    do_op(1, 15'h0003, 8'h3C, 0);
    do_op(1, 15'h0004, 8'hC3, 0);
    do_op(0, 15'h0003, 8'h00, 0);
    do_op(0, 15'h0004, 8'h00, 1);
    do_op(1, 15'h7FFF, 8'hFF, 1);
    do_op(0, 15'h7FFC, 8'h00, 0);
    do_op(0, 15'h7FFF, 8'h00, 0);
    do_op(1, 15'h0005, 8'h5A, 0);
    do_op(0, 15'h0006, 8'h00, 0);

    rnd = $urandom(32'd1808);
    for (int i = 0; i < 16; i++) rows[i] = 15'($urandom) & 15'h7FFC;
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      a = rows[$urandom % 16] | 15'($urandom % 4);
      do_op(1'($urandom % 2), a, 8'($urandom), ($urandom % 8) == 0);
    end

    chk("R3 address stable a", mov_a, 0);
    chk("R3 address stable b", mov_b, 0);
    chk("R6 no contention a", con_a, 0);
    chk("R6 no contention b", con_b, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule